// File: doc/BRIEF.md
# Cascaded Secondary Interrupt Controller

This block collects a parameterised set of peripheral interrupt lines (23 or 28) and merges them into a single request for a primary interrupt controller. Each line passes through a two-stage synchroniser. A per-source kind bit then treats the line as level-sensitive or as edge-triggered. A per-source polarity bit picks active-high or rising when clear, and active-low or falling when set. Edge events, and events raised by firmware, are held in a pending latch until software acknowledges them.

Software works through a small synchronous register port. Reads have no side effects and return data in the same cycle as the address. Writes take effect at the next clock edge.

The enable mask changes only through write-one-to-set and write-one-to-clear registers, so a driver never needs a read-modify-write to change one source. Two views are offered. The source view shows every active source without the mask. The request view shows only the enabled ones. The cascade output is a registered OR of the request view.

Top module: `cirq_ctrl`

## Requirements
- R1: After reset the enable, kind, polarity and pending state are all zero, and `irq_o` is low.
- R2: Writing offset 0x0C sets each enable bit whose data bit is 1. Bits written as 0 keep their value. The enable mask reads back at offset 0x04.
- R3: Writing offset 0x08 clears each enable bit whose data bit is 1. Bits written as 0 keep their value.
- R4: A source with kind bit 0 (offset 0x10) and polarity bit 0 (offset 0x14) is level-sensitive and active-high. Bit n of the source view (offset 0x24) follows synchronised input n and is not latched.
- R5: A level source with polarity bit 1 is active when its input is low.
- R6: A source with kind bit 1 and polarity bit 0 latches a rising input edge. The latch stays set after the input falls.
- R7: A source with kind bit 1 and polarity bit 1 latches falling edges and ignores rising edges.
- R8: Writing 1 to bit n of offset 0x28 clears pending latch n. An edge detected in the same cycle as that write wins, and the latch stays set.
- R9: The request view (offset 0x1C) is the source view ANDed with the enable mask, with source n on bit n.
- R10: Data bits at and above the source count read as zero in every register and have no effect when written.
- R11: `irq_o` is the OR of the request view, registered: it changes one clock after the request view does.
- R12: Writing 1 to bit n of offset 0x2C sets pending latch n as if an edge had arrived, for either kind.
- R13: An edge source whose input stays at its active level after being acknowledged does not become pending again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_i | input | NSRC | Asynchronous peripheral interrupt lines |
| bus_addr_i | input | 6 | Byte offset of the register being accessed |
| bus_wr_i | input | 1 | Write strobe, sampled at the clock edge |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i`, combinational |
| irq_o | output | 1 | Merged request to the primary controller |

## Verification
The bench aims an acknowledge at the exact cycle in which a synchronised edge is latched. A design that lets the clear win would lose that interrupt, and the source view would read zero.

It holds an edge input high across an acknowledge. A design that re-arms on level would report the source pending again.

It writes all ones to every register of a 23-source build. Upper bits that are kept or decoded would then read as nonzero.

It checks `irq_o` one cycle before and on the cycle it should rise. A combinational or doubly registered cascade would fail one of the two samples.

// File: rtl/cirq_pkg.sv
package cirq_pkg;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 6;

    localparam logic [ADDR_W-1:0] OFS_ENA     = 6'h04;
    localparam logic [ADDR_W-1:0] OFS_ENA_CLR = 6'h08;
    localparam logic [ADDR_W-1:0] OFS_ENA_SET = 6'h0C;
    localparam logic [ADDR_W-1:0] OFS_KIND    = 6'h10;
    localparam logic [ADDR_W-1:0] OFS_POL     = 6'h14;
    localparam logic [ADDR_W-1:0] OFS_REQ     = 6'h1C;
    localparam logic [ADDR_W-1:0] OFS_SRC     = 6'h24;
    localparam logic [ADDR_W-1:0] OFS_ACK     = 6'h28;
    localparam logic [ADDR_W-1:0] OFS_SWTRIG  = 6'h2C;
endpackage

// File: rtl/cirq_sync.sv
module cirq_sync #(
    parameter int N = 28
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] src_i,
    output logic [N-1:0] lvl_o,
    output logic [N-1:0] rise_o,
    output logic [N-1:0] fall_o
);
    typedef struct packed {
        logic [N-1:0] s1;
        logic [N-1:0] s2;
        logic [N-1:0] s3;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = src_i;
        st_d.s2 = st_q.s1;
        st_d.s3 = st_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lvl_o  = st_q.s2;
    assign rise_o = st_q.s2 & ~st_q.s3;
    assign fall_o = ~st_q.s2 & st_q.s3;
endmodule

// File: rtl/cirq_pend.sv
module cirq_pend #(
    parameter int N = 28
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] kind_i,
    input  logic [N-1:0] pol_i,
    input  logic [N-1:0] lvl_i,
    input  logic [N-1:0] rise_i,
    input  logic [N-1:0] fall_i,
    input  logic [N-1:0] ack_i,
    input  logic [N-1:0] swtrig_i,
    output logic [N-1:0] edge_hit_o,
    output logic [N-1:0] latch_o,
    output logic [N-1:0] src_view_o
);
    logic [N-1:0] latch_d, latch_q;

    for (genvar g = 0; g < N; g++) begin : g_src
        assign edge_hit_o[g] = kind_i[g] & (pol_i[g] ? fall_i[g] : rise_i[g]);
        assign src_view_o[g] = latch_q[g] | (~kind_i[g] & (lvl_i[g] ^ pol_i[g]));
    end

    always_comb begin
        latch_d = (latch_q & ~ack_i) | edge_hit_o | swtrig_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) latch_q <= '0;
        else        latch_q <= latch_d;
    end

    assign latch_o = latch_q;
endmodule

// File: rtl/cirq_ctrl.sv
module cirq_ctrl
    import cirq_pkg::*;
#(
    parameter int NSRC = 28
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NSRC-1:0]     src_i,
    input  logic [ADDR_W-1:0]   bus_addr_i,
    input  logic                bus_wr_i,
    input  logic [DATA_W-1:0]   bus_wdata_i,
    output logic [DATA_W-1:0]   bus_rdata_o,
    output logic                irq_o
);
    typedef struct packed {
        logic [NSRC-1:0] ena;
        logic [NSRC-1:0] kind;
        logic [NSRC-1:0] pol;
        logic            irq;
    } regs_t;

    regs_t r_d, r_q;

    logic [NSRC-1:0] wbits;
    logic [NSRC-1:0] set_w, clr_w, ack_w, sw_w;
    logic [NSRC-1:0] lvl, rise, fall;
    logic [NSRC-1:0] edge_hit, latch, src_view, req_view;

    assign wbits = bus_wdata_i[NSRC-1:0];

    always_comb begin
        set_w = '0;
        clr_w = '0;
        ack_w = '0;
        sw_w  = '0;
        if (bus_wr_i) begin
            case (bus_addr_i)
                OFS_ENA_SET: set_w = wbits;
                OFS_ENA_CLR: clr_w = wbits;
                OFS_ACK:     ack_w = wbits;
                OFS_SWTRIG:  sw_w  = wbits;
                default: ;
            endcase
        end
    end

    cirq_sync #(.N(NSRC)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .src_i  (src_i),
        .lvl_o  (lvl),
        .rise_o (rise),
        .fall_o (fall)
    );

    cirq_pend #(.N(NSRC)) u_pend (
        .clk        (clk),
        .rst_n      (rst_n),
        .kind_i     (r_q.kind),
        .pol_i      (r_q.pol),
        .lvl_i      (lvl),
        .rise_i     (rise),
        .fall_i     (fall),
        .ack_i      (ack_w),
        .swtrig_i   (sw_w),
        .edge_hit_o (edge_hit),
        .latch_o    (latch),
        .src_view_o (src_view)
    );

    assign req_view = src_view & r_q.ena;

    always_comb begin
        r_d     = r_q;
        r_d.ena = (r_q.ena & ~clr_w) | set_w;
        if (bus_wr_i && bus_addr_i == OFS_KIND) r_d.kind = wbits;
        if (bus_wr_i && bus_addr_i == OFS_POL)  r_d.pol  = wbits;
        r_d.irq = |req_view;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        bus_rdata_o = '0;
        case (bus_addr_i)
            OFS_ENA:  bus_rdata_o[NSRC-1:0] = r_q.ena;
            OFS_KIND: bus_rdata_o[NSRC-1:0] = r_q.kind;
            OFS_POL:  bus_rdata_o[NSRC-1:0] = r_q.pol;
            OFS_REQ:  bus_rdata_o[NSRC-1:0] = req_view;
            OFS_SRC:  bus_rdata_o[NSRC-1:0] = src_view;
            default: ;
        endcase
    end

    assign irq_o = r_q.irq;
endmodule

// File: rtl/cirq_ctrl_chk.sv
module cirq_ctrl_chk #(
    parameter int N = 28
) (
    input logic         clk,
    input logic         rst_n,
    input logic         irq_o,
    input logic [N-1:0] ena,
    input logic [N-1:0] src_view,
    input logic [N-1:0] req_view,
    input logic [N-1:0] latch,
    input logic [N-1:0] edge_hit,
    input logic [N-1:0] set_w,
    input logic [N-1:0] clr_w,
    input logic [N-1:0] ack_w,
    input logic [N-1:0] sw_w
);
    AST_ENA_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (set_w != '0) |=> ((ena & $past(set_w)) == $past(set_w))); // R2

    AST_ENA_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_w != '0) |=> ((ena & $past(clr_w)) == '0)); // R3

    AST_EDGE_BEATS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        ((edge_hit & ack_w) != '0) |=> ((latch & $past(edge_hit)) == $past(edge_hit))); // R8

    AST_SWTRIG_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_w != '0) |=> ((latch & $past(sw_w)) == $past(sw_w))); // R12

    AST_REQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        ((req_view & ~ena) == '0)); // R9

    AST_CASCADE_REG: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_o == $past(|(src_view & ena)))); // R11
endmodule

bind cirq_ctrl cirq_ctrl_chk #(.N(NSRC)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq_o    (irq_o),
    .ena      (r_q.ena),
    .src_view (src_view),
    .req_view (req_view),
    .latch    (latch),
    .edge_hit (edge_hit),
    .set_w    (set_w),
    .clr_w    (clr_w),
    .ack_w    (ack_w),
    .sw_w     (sw_w)
);

// File: tb/cirq_ctrl_bench.sv
module cirq_ctrl_bench;
    localparam int NS = 23;
    localparam logic [31:0] ALLSRC = 32'h007F_FFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [NS-1:0] src = '0;
    logic [5:0]  addr = '0;
    logic        wr = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    cirq_ctrl #(.NSRC(NS)) u_cirq_ctrl (
        .clk(clk), .rst_n(rst_n), .src_i(src),
        .bus_addr_i(addr), .bus_wr_i(wr), .bus_wdata_i(wdata),
        .bus_rdata_o(rdata), .irq_o(irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [5:0] a, output logic [31:0] d);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd_reg(6'h04, v); check("R1 enable", v, 0);
        rd_reg(6'h10, v); check("R1 kind", v, 0);
        rd_reg(6'h14, v); check("R1 polarity", v, 0);
        rd_reg(6'h24, v); check("R1 source view", v, 0);
        check("R1 irq", {31'd0, irq}, 0);
    endtask

    task automatic t_enable();
        logic [31:0] v;
        wr_reg(6'h0C, 32'h5); rd_reg(6'h04, v); check("R2 set", v, 32'h5);
        wr_reg(6'h0C, 32'h2); rd_reg(6'h04, v); check("R2 zeros keep", v, 32'h7);
        wr_reg(6'h08, 32'h4); rd_reg(6'h04, v); check("R3 clear", v, 32'h3);
        wr_reg(6'h08, 32'hFFFF_FFFF); rd_reg(6'h04, v); check("R3 clear all", v, 0);
    endtask

    task automatic t_level();
        logic [31:0] v;
        wr_reg(6'h0C, 32'h8);
        src[3] = 1'b1; settle();
        rd_reg(6'h24, v); check("R4 level high", v, 32'h8);
        rd_reg(6'h1C, v); check("R9 bit map", v, 32'h8);
        check("R11 irq high", {31'd0, irq}, 1);
        src[3] = 1'b0; settle();
        rd_reg(6'h24, v); check("R4 not latched", v, 0);
        check("R11 irq low", {31'd0, irq}, 0);
        wr_reg(6'h14, 32'h10); settle();
        rd_reg(6'h24, v); check("R5 active low", v, 32'h10);
        rd_reg(6'h1C, v); check("R9 masked", v, 0);
        src[4] = 1'b1; settle();
        rd_reg(6'h24, v); check("R5 inactive high", v, 0);
        src[4] = 1'b0;
        wr_reg(6'h14, 32'h0);
        wr_reg(6'h08, 32'h8);
        settle();
    endtask

    task automatic t_edge();
        logic [31:0] v;
        wr_reg(6'h10, 32'h60);
        wr_reg(6'h14, 32'h40);
        src[5] = 1'b1; settle();
        rd_reg(6'h24, v); check("R6 rising latched", v, 32'h20);
        src[5] = 1'b0; settle();
        rd_reg(6'h24, v); check("R6 held", v, 32'h20);
        src[5] = 1'b1; settle();
        wr_reg(6'h28, 32'h20); settle();
        rd_reg(6'h24, v); check("R8 ack clears", v, 0);
        check("R13 no rearm on level", v, 0);
        src[5] = 1'b0;
        src[6] = 1'b1; settle();
        rd_reg(6'h24, v); check("R7 rising ignored", v, 0);
        src[6] = 1'b0; settle();
        rd_reg(6'h24, v); check("R7 falling latched", v, 32'h40);
        wr_reg(6'h28, 32'h40); settle();
    endtask

    task automatic t_ack_race();
        logic [31:0] v;
        wr_reg(6'h10, 32'h80);
        wr_reg(6'h14, 32'h0);
        @(negedge clk); src[7] = 1'b1;
        @(posedge clk); @(posedge clk);
        wr_reg(6'h28, 32'h80);
        rd_reg(6'h24, v); check("R8 edge beats ack", v, 32'h80);
        wr_reg(6'h28, 32'h80);
        rd_reg(6'h24, v); check("R8 later ack", v, 0);
        src[7] = 1'b0;
        wr_reg(6'h10, 32'h0); settle();
    endtask

    task automatic t_swtrig();
        logic [31:0] v;
        wr_reg(6'h0C, 32'h200);
        wr_reg(6'h2C, 32'h200);
        rd_reg(6'h1C, v); check("R12 sw pending", v, 32'h200);
        check("R11 irq one cycle late", {31'd0, irq}, 0);
        @(negedge clk);
        check("R11 irq registered", {31'd0, irq}, 1);
        wr_reg(6'h28, 32'h200); settle();
        rd_reg(6'h24, v); check("R12 sw acked", v, 0);
        check("R11 irq drops", {31'd0, irq}, 0);
        wr_reg(6'h08, 32'h200);
    endtask

    task automatic t_width();
        logic [31:0] v;
        wr_reg(6'h10, 32'hFFFF_FFFF); rd_reg(6'h10, v); check("R10 kind upper", v, ALLSRC);
        wr_reg(6'h14, 32'hFFFF_FFFF); rd_reg(6'h14, v); check("R10 pol upper", v, ALLSRC);
        wr_reg(6'h0C, 32'hFFFF_FFFF); rd_reg(6'h04, v); check("R10 ena upper", v, ALLSRC);
        wr_reg(6'h2C, 32'hFFFF_FFFF);
        rd_reg(6'h24, v); check("R10 source upper", v, ALLSRC);
        rd_reg(6'h1C, v); check("R10 request upper", v, ALLSRC);
        wr_reg(6'h28, 32'hFFFF_FFFF);
        wr_reg(6'h14, 32'h0);
        wr_reg(6'h10, 32'h0);
        wr_reg(6'h08, 32'hFFFF_FFFF);
        rd_reg(6'h24, v); check("R10 all acked", v, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_enable();
        t_level();
        t_edge();
        t_ack_race();
        t_swtrig();
        t_width();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #(8 * 100000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule